// File: doc/BRIEF.md
# Byte Stream to Datagram Bridge

This block connects processor logic that speaks a simple byte-at-a-time handshake, like a UART, to a datagram transmit port. Each outgoing byte enters a small FIFO with a ninth bit, the flush mark. A packetizer drains the FIFO into a payload buffer. The payload is released when it reaches `MAX_LEN` bytes, or as soon as a byte with the flush mark has been taken in. The released payload goes out as a burst of beats. The first beat is flagged as the start and the final beat as the last, and every beat carries the payload length.

After each payload, the transmit side waits a programmable number of cycles before it gathers the next one. This stops a slow host from being flooded. On the receive side, incoming payload bytes are handed to the processor one at a time, with a programmable quiet time after each delivered byte.

Top module: `byte_dgram_bridge`

## Requirements
- R1: After reset, `tx_ready` is 1, `pkt_valid` is 0 and `out_valid` is 0.
- R2: When a byte with `tx_flush`=1 is accepted, the payload closes with that byte as its final beat. It is sent at once, even if it holds fewer than `MAX_LEN` bytes.
- R3: A payload that reaches `MAX_LEN` bytes is sent without any flush mark. The following bytes begin a new payload.
- R4: Payload bytes leave in the order they were accepted. `pkt_start`=1 on the first beat only and `pkt_last`=1 on the final beat only. `pkt_len` holds the payload byte count on every beat.
- R5: While `pkt_valid`=1 and `pkt_ready`=0, `pkt_valid`, `pkt_data` and `pkt_len` hold steady.
- R6: When the FIFO holds `DEPTH` bytes and the packetizer cannot drain it, `tx_ready` is 0. Every byte accepted is later sent, and none is lost.
- R7: `pkt_len` is never 0 and never above `MAX_LEN` while `pkt_valid`=1.
- R8: Suppose the final beat of a payload is accepted at edge e, and the next payload is a single flushed byte that is already queued. Then that next payload's `pkt_valid` rises after edge e+`tx_gap`+1.
- R9: Received bytes reach `out_data` in arrival order. While `out_ready`=0, `out_valid` and `out_data` hold steady and `rx_ready` stays 0.
- R10: With `rx_valid` and `out_ready` held at 1, successive delivery handshakes are exactly `rx_gap`+2 cycles apart. After each delivery with `rx_gap`≠0, `rx_ready` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Outgoing byte offered |
| tx_ready | output | 1 | FIFO can take a byte |
| tx_data | input | 8 | Outgoing byte |
| tx_flush | input | 1 | Close the payload after this byte |
| tx_gap | input | GAP_W | Pause cycles after each sent payload |
| pkt_valid | output | 1 | Payload beat valid |
| pkt_ready | input | 1 | Datagram port accepts beat |
| pkt_data | output | 8 | Payload byte |
| pkt_start | output | 1 | First beat of payload |
| pkt_last | output | 1 | Final beat of payload |
| pkt_len | output | LW | Payload byte count |
| rx_valid | input | 1 | Incoming payload byte offered |
| rx_ready | output | 1 | Receive side can take a byte |
| rx_data | input | 8 | Incoming payload byte |
| rx_gap | input | GAP_W | Quiet cycles after each delivered byte |
| out_valid | output | 1 | Byte offered to processor logic |
| out_ready | input | 1 | Processor logic takes the byte |
| out_data | output | 8 | Delivered byte |

## Verification
Three payload shapes are tried. A short payload ended by a flush mark shows that early release works and that the length counts the flushed byte. A run with no flush mark shows closure at the maximum length, then a continuation payload. A burst pushed while the datagram port is stalled fills the FIFO, which separates correct back-pressure from a lost or duplicated byte. Pacing is measured with two single-byte flushed payloads queued back to back, and with a continuous receive stream. Each is checked at both a zero and a nonzero gap, so an off-by-one in either counter is caught.

// File: rtl/byte_dgram_bridge.sv
module byte_dgram_bridge #(
  parameter int DEPTH   = 16,
  parameter int MAX_LEN = 64,
  parameter int GAP_W   = 16,
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  input  logic             tx_flush,
  input  logic [GAP_W-1:0] tx_gap,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [7:0]       pkt_data,
  output logic             pkt_start,
  output logic             pkt_last,
  output logic [LW-1:0]    pkt_len,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic [GAP_W-1:0] rx_gap,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = $clog2(MAX_LEN);

  typedef enum logic [1:0] {COLLECT, SEND, PAUSE} st_t;

  logic [8:0]       mem [DEPTH];
  logic [7:0]       pbuf [MAX_LEN];
  logic [AW:0]      wptr, rptr;
  logic [LW-1:0]    cnt, len;
  logic [GAP_W-1:0] tgap, rgap;
  logic [7:0]       hold;
  logic             hfull;
  st_t              st;

  wire       empty = (wptr == rptr);
  wire       full  = (wptr[AW-1:0] == rptr[AW-1:0]) && (wptr[AW] != rptr[AW]);
  wire       push  = tx_valid && tx_ready;
  wire       pop   = (st == COLLECT) && !empty;
  wire [8:0] head  = mem[rptr[AW-1:0]];

  assign tx_ready  = !full;
  assign pkt_valid = (st == SEND);
  assign pkt_data  = pbuf[cnt[IW-1:0]];
  assign pkt_start = (cnt == '0);
  assign pkt_last  = (cnt == len - 1'b1);
  assign pkt_len   = len;

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= {tx_flush, tx_data};
    if (pop)  pbuf[cnt[IW-1:0]] <= head[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      len  <= '0;
      tgap <= '0;
      st   <= COLLECT;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case (st)
        COLLECT:
          if (pop) begin
            if (head[8] || cnt == LW'(MAX_LEN - 1)) begin
              len <= cnt + 1'b1;
              cnt <= '0;
              st  <= SEND;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        SEND:
          if (pkt_ready) begin
            if (pkt_last) begin
              cnt <= '0;
              if (tx_gap == '0) st <= COLLECT;
              else begin
                tgap <= tx_gap;
                st   <= PAUSE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        default: begin
          tgap <= tgap - 1'b1;
          if (tgap == GAP_W'(1)) st <= COLLECT;
        end
      endcase
    end
  end

  assign rx_ready  = !hfull && (rgap == '0);
  assign out_valid = hfull;
  assign out_data  = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hfull <= 1'b0;
      hold  <= '0;
      rgap  <= '0;
    end else if (rx_valid && rx_ready) begin
      hold  <= rx_data;
      hfull <= 1'b1;
    end else if (out_valid && out_ready) begin
      hfull <= 1'b0;
      rgap  <= rx_gap;
    end else if (rgap != '0) begin
      rgap <= rgap - 1'b1;
    end
  end

  // R7
  pkt_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len != '0) && (pkt_len <= LW'(MAX_LEN)));
  // R5
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data) && $stable(pkt_len));
  // R4
  pkt_start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && !pkt_last |=> pkt_valid && !pkt_start);
  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready && st != COLLECT |=> !tx_ready);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && !rx_ready);
  // R10
  rx_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && rx_gap != '0 |=> !rx_ready);
endmodule

// File: tb/test_byte_dgram_bridge.sv
module test_byte_dgram_bridge;
  localparam int DEPTH = 4, MAXL = 8, GW = 8;
  localparam int LW = $clog2(MAXL + 1);

  logic clk = 0, rst_n = 0;
  logic tx_valid = 0, tx_flush = 0, pkt_ready = 0, rx_valid = 0, out_ready = 0;
  logic [7:0] tx_data = 0, rx_data = 0;
  logic [GW-1:0] tx_gap = 0, rx_gap = 0;
  logic tx_ready, pkt_valid, pkt_start, pkt_last, rx_ready, out_valid;
  logic [7:0] pkt_data, out_data;
  logic [LW-1:0] pkt_len;

  int tests = 0, fails = 0, cyc = 0;
  int exp_q [64];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  byte_dgram_bridge #(.DEPTH(DEPTH), .MAX_LEN(MAXL), .GAP_W(GW)) i_byte_dgram_bridge (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_flush(tx_flush), .tx_gap(tx_gap), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .pkt_start(pkt_start), .pkt_last(pkt_last), .pkt_len(pkt_len),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_gap(rx_gap),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input bit f);
    tx_valid = 1; tx_data = d; tx_flush = f;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0; tx_flush = 0;
  endtask

  task automatic recv(input int n, input string r);
    pkt_ready = 1;
    for (int i = 0; i < n; i++) begin
      while (!pkt_valid) @(negedge clk);
      chk(pkt_data == exp_q[i], {r, " data"}, pkt_data, exp_q[i]);
      chk(pkt_start == (i == 0), {r, " start"}, pkt_start, i == 0);
      chk(pkt_last == (i == n - 1), {r, " last"}, pkt_last, i == n - 1);
      chk(pkt_len == n, {r, " len"}, pkt_len, n);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(tx_ready == 1, "R1 tx_ready", tx_ready, 1);
    chk(pkt_valid == 0, "R1 pkt_valid", pkt_valid, 0);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
  endtask

  task automatic t_flush_short();
    pkt_ready = 0;
    push(8'h11, 0); push(8'h22, 0); push(8'h33, 1);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(pkt_valid == 1 && pkt_data == 8'h11 && pkt_len == 3, "R5 stall hold", pkt_data, 8'h11);
      @(negedge clk);
    end
    exp_q[0] = 8'h11; exp_q[1] = 8'h22; exp_q[2] = 8'h33;
    recv(3, "R2 R4 flush payload");
    repeat (3) @(negedge clk);
    chk(pkt_valid == 0, "R7 no empty payload", pkt_valid, 0);
  endtask

  task automatic t_max_and_full();
    pkt_ready = 0;
    for (int i = 0; i < 12; i++) push(8'h40 + 8'(i), 0);
    repeat (2) @(negedge clk);
    chk(tx_ready == 0, "R6 full blocks", tx_ready, 0);
    for (int i = 0; i < 8; i++) exp_q[i] = 8'h40 + i;
    fork
      recv(8, "R3 max payload");
      push(8'h4C, 1);
    join
    for (int i = 0; i < 5; i++) exp_q[i] = 8'h48 + i;
    recv(5, "R6 R4 follow payload");
  endtask

  task automatic t_tx_gap(input int g);
    int k;
    tx_gap = GW'(g); pkt_ready = 0;
    push(8'hA1, 1); push(8'hB2, 1);
    exp_q[0] = 8'hA1;
    recv(1, "R8 first");
    k = 1;
    while (!pkt_valid && k < 100) begin @(negedge clk); k++; end
    chk(k == g + 2, "R8 tx pause", k, g + 2);
    exp_q[0] = 8'hB2;
    recv(1, "R8 second");
    tx_gap = 0;
  endtask

  task automatic t_rx_pace(input int g);
    int last;
    rx_gap = GW'(g); out_ready = 1; last = 0;
    fork
      for (int i = 0; i < 5; i++) begin
        rx_valid = 1; rx_data = 8'h30 + 8'(i);
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
      end
      for (int j = 0; j < 5; j++) begin
        while (!out_valid) @(negedge clk);
        chk(out_data == 8'h30 + j, "R9 rx order", out_data, 8'h30 + j);
        if (j > 0) chk(cyc - last == g + 2, "R10 rx spacing", cyc - last, g + 2);
        last = cyc;
        @(negedge clk);
      end
    join
    rx_valid = 0;
    repeat (g + 3) @(negedge clk);
  endtask

  task automatic t_rx_stall();
    rx_gap = 0; out_ready = 0;
    rx_valid = 1; rx_data = 8'hA5;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_data = 8'h5A;
    repeat (4) @(negedge clk);
    chk(out_valid == 1 && out_data == 8'hA5, "R9 stall hold", out_data, 8'hA5);
    chk(rx_ready == 0, "R9 stall no take", rx_ready, 0);
    out_ready = 1;
    @(negedge clk);
    @(negedge clk);
    rx_valid = 0;
    while (!out_valid) @(negedge clk);
    chk(out_data == 8'h5A, "R9 after stall", out_data, 8'h5A);
    @(negedge clk);
    out_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_flush_short();
    t_max_and_full();
    t_tx_gap(0);
    t_tx_gap(5);
    t_rx_pace(0);
    t_rx_pace(3);
    t_rx_stall();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule